// File: doc/BRIEF.md
# Nearest-Codevector Search Engine

This block runs a full codebook search for a vector quantizer. A stream of component pairs arrives one pair per clock: a component of the input vector on one 12-bit bus and the matching component of the current codevector on the other. Each pair goes through a pipeline with no stalls. The pipeline forms a two's-complement difference, takes its magnitude without a branch, and squares the magnitude with a split-operand squarer. It then adds the square into a per-codevector accumulator. When the last component of a codevector has been added, the distortion is compared with a running minimum. A smaller value replaces the minimum and records the codevector's index.

Every codevector costs exactly `k` cycles of stream bandwidth. Searches follow each other with no gap. Once the last component of the last codevector has been accepted, the next valid pair opens the search for the next input vector. No marker is needed for this. A start marker re-synchronises the engine at any time. The dimension `k` (1 to 8) and the codebook size `N` (1 to 512) are sampled when each search opens.

The stream front end is a two-state machine. `ST_AWAIT_START` is the state after reset; it ignores traffic until a valid pair carries the start marker. That transition is called *open*; when it does not occur, the machine takes *hold* and stays. `ST_SEARCHING` takes *run* on every cycle. Inside that state the component and codevector counters either restart (start marker), advance, or wrap to the next search.

Top module: `vq_search_engine`

## Requirements
- R1: Components are 12-bit two's complement. The distortion of codevector j is the sum, over its k components, of (x_i - y_i)^2. Codevectors are numbered 0..N-1 in arrival order. The index reported for a search is that of the codevector with the smallest distortion.
- R2: When two codevectors have equal distortion, the lower index wins; a later codevector replaces the minimum only if it is strictly smaller.
- R3: Every search starts from an all-ones 27-bit reference, so nothing from the previous search affects its result; the reference is back at all-ones when the done strobe is raised.
- R4: `match_done` is high for one cycle per completed search, on the 6th rising edge counting the edge that sampled the search's last component as the 1st. `match_idx` changes only together with `match_done` and holds the winner until the next strobe. After reset both outputs are 0.
- R5: After the last component of codevector N-1, the next valid pair is component 0 of codevector 0 of a new search, with no marker and no idle cycle required. Searches with k = 1 and N = 1 give a strobe on consecutive cycles.
- R6: Cycles with `in_valid` low (with any data or marker value) are ignored: they neither advance the counters nor add to any distortion, and stage 0 holds no valid pair on the following cycle.
- R7: A valid pair with `in_start` high is component 0 of codevector 0 of a new search. Any search in progress is dropped without a strobe.
- R8: After reset, valid pairs without `in_start` are ignored and produce no strobe; `match_done` stays low during reset.
- R9: `cfg_dim` and `cfg_size` are sampled only on the pair that opens a search (marker or wrap); changes during a search have no effect on it.
- R10: Full-range differences (-2048 against 2047, magnitude 4095, square 16769025) accumulate over 8 components without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Component pair present this cycle |
| in_start | input | 1 | Pair is the first of a new search |
| vec_comp | input | 12 | Input-vector component, two's complement |
| code_comp | input | 12 | Codevector component, two's complement |
| cfg_dim | input | 4 | Vector dimension k, 1 to 8 |
| cfg_size | input | 10 | Codebook size N, 1 to 512 |
| match_done | output | 1 | One-cycle strobe at the end of each search |
| match_idx | output | 9 | Index of the best codevector of the last search |

## Verification
The hardest conditions to reach from the ports are a search that ends in the same cycle another opens, and a search torn off halfway by a marker. The bench gets there by sweeping every dimension against several codebook sizes as one unbroken back-to-back stream, including k = 1, N = 1 runs, and by cutting partial searches with a fresh marker. Ties are forced by copying the winning codevector into a later or earlier slot. Full-range components push the accumulator to its bound. Random idle cycles and configuration changes in the middle of a search are mixed into the stream. Every expected index and strobe cycle is computed from the bench's own copy of the data.

// File: rtl/vq_pkg.sv
`timescale 1ns/1ps
package vq_pkg;

    typedef enum logic [0:0] {
        ST_AWAIT_START = 1'b0,
        ST_SEARCHING   = 1'b1
    } vq_state_e;

    typedef struct packed {
        logic valid;
        logic first_comp;
        logic last_comp;
        logic first_cv;
        logic last_cv;
    } vq_flags_t;

    localparam int FLAG_W = $bits(vq_flags_t);

endpackage

// File: rtl/vq_stream_tagger.sv
`timescale 1ns/1ps
module vq_stream_tagger
    import vq_pkg::*;
#(
    parameter int DW   = 12,
    parameter int KMAX = 8,
    parameter int NMAX = 512,
    localparam int KW   = $clog2(KMAX + 1),
    localparam int NW   = $clog2(NMAX + 1),
    localparam int IDXW = $clog2(NMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_start,
    input  logic [DW-1:0]   vec_comp,
    input  logic [DW-1:0]   code_comp,
    input  logic [KW-1:0]   cfg_dim,
    input  logic [NW-1:0]   cfg_size,
    output logic [DW-1:0]   x_q,
    output logic [DW-1:0]   y_q,
    output vq_flags_t       flags_q,
    output logic [IDXW-1:0] idx_q
);

    vq_state_e       state_q, state_d;
    logic [KW-1:0]   comp_q, k_q, cur_comp, eff_k;
    logic [NW-1:0]   cv_q, n_q, cur_cv, eff_n;
    logic            accept, opens, is_last_comp, is_last_cv;

    // position of the pair on the inputs within its search
    always_comb begin
        accept       = in_valid && (in_start || state_q == ST_SEARCHING);
        opens        = in_valid && (in_start ||
                       (state_q == ST_SEARCHING && comp_q == '0 && cv_q == '0));
        eff_k        = opens ? cfg_dim : k_q;
        eff_n        = opens ? cfg_size : n_q;
        cur_comp     = in_start ? '0 : comp_q;
        cur_cv       = in_start ? '0 : cv_q;
        is_last_comp = (cur_comp == eff_k - KW'(1));
        is_last_cv   = (cur_cv == eff_n - NW'(1));
    end

    // transitions: open, hold, run
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAIT_START: state_d = (in_valid && in_start) ? ST_SEARCHING : ST_AWAIT_START;
            ST_SEARCHING:   state_d = ST_SEARCHING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAIT_START;
        else        state_q <= state_d;
    end

    // component and codevector counters, configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_q <= '0;
            cv_q   <= '0;
            k_q    <= '0;
            n_q    <= '0;
        end else if (accept) begin
            if (opens) begin
                k_q <= cfg_dim;
                n_q <= cfg_size;
            end
            if (is_last_comp) begin
                comp_q <= '0;
                cv_q   <= is_last_cv ? '0 : cur_cv + NW'(1);
            end else begin
                comp_q <= cur_comp + KW'(1);
                cv_q   <= cur_cv;
            end
        end
    end

    // stage 0 outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q     <= '0;
            y_q     <= '0;
            flags_q <= '0;
            idx_q   <= '0;
        end else begin
            x_q                <= vec_comp;
            y_q                <= code_comp;
            flags_q.valid      <= accept;
            flags_q.first_comp <= (cur_comp == '0);
            flags_q.last_comp  <= is_last_comp;
            flags_q.first_cv   <= (cur_cv == '0);
            flags_q.last_cv    <= is_last_cv;
            idx_q              <= cur_cv[IDXW-1:0];
        end
    end

endmodule

// File: rtl/vq_absdiff.sv
`timescale 1ns/1ps
module vq_absdiff #(
    parameter int DW = 12,
    parameter int TW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [TW-1:0] tag_i,
    output logic [DW-1:0] mag_o,
    output logic [TW-1:0] tag_o
);

    // stage 1: a + not(b) = a - b - 1, one sign-extended add
    logic [DW:0]   s1_q;
    logic [TW-1:0] tag1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= '0;
            tag1_q <= '0;
        end else begin
            s1_q   <= {a_i[DW-1], a_i} + ~{b_i[DW-1], b_i};
            tag1_q <= tag_i;
        end
    end

    // stage 2: one operation whatever the sign: increment or invert
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mag_o <= '0;
            tag_o <= '0;
        end else begin
            mag_o <= s1_q[DW] ? ~s1_q[DW-1:0] : s1_q[DW-1:0] + DW'(1);
            tag_o <= tag1_q;
        end
    end

endmodule

// File: rtl/vq_squarer.sv
`timescale 1ns/1ps
module vq_squarer #(
    parameter int DW = 12,
    parameter int TW = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   mag_i,
    input  logic [TW-1:0]   tag_i,
    output logic [2*DW-1:0] sq_o,
    output logic [TW-1:0]   tag_o
);

    localparam int H   = DW / 2;
    localparam int L   = DW - H;
    localparam int SQW = 2 * DW;

    logic [H-1:0]   hi;
    logic [L-1:0]   lo;
    logic [2*H-1:0] hh_q;
    logic [H+L-1:0] hl_q;
    logic [2*L-1:0] ll_q;
    logic [TW-1:0]  tag3_q;

    assign hi = mag_i[DW-1:L];
    assign lo = mag_i[L-1:0];

    // stage 3: three narrow partial products
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hh_q   <= '0;
            hl_q   <= '0;
            ll_q   <= '0;
            tag3_q <= '0;
        end else begin
            hh_q   <= {{H{1'b0}}, hi} * {{H{1'b0}}, hi};
            hl_q   <= {{L{1'b0}}, hi} * {{H{1'b0}}, lo};
            ll_q   <= {{L{1'b0}}, lo} * {{L{1'b0}}, lo};
            tag3_q <= tag_i;
        end
    end

    // stage 4: (h*2^L + l)^2 = h^2*2^2L + 2hl*2^L + l^2
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_o  <= '0;
            tag_o <= '0;
        end else begin
            sq_o  <= (SQW'(hh_q) << (2 * L)) + (SQW'(hl_q) << (L + 1)) + SQW'(ll_q);
            tag_o <= tag3_q;
        end
    end

endmodule

// File: rtl/vq_min_tracker.sv
`timescale 1ns/1ps
module vq_min_tracker
    import vq_pkg::*;
#(
    parameter int SQW  = 24,
    parameter int KMAX = 8,
    parameter int IDXW = 9,
    localparam int ACCW = SQW + $clog2(KMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SQW-1:0]  sq_i,
    input  vq_flags_t       flags_i,
    input  logic [IDXW-1:0] idx_i,
    output logic            done_o,
    output logic [IDXW-1:0] best_idx_o,
    output logic [ACCW-1:0] err_o
);

    logic [ACCW-1:0] acc_q, err_q, acc_sum, ref_v;
    logic [IDXW-1:0] best_q;
    logic            better, closes;

    always_comb begin
        acc_sum = flags_i.first_comp ? ACCW'(sq_i) : acc_q + ACCW'(sq_i);
        ref_v   = flags_i.first_cv ? '1 : err_q;
        better  = acc_sum < ref_v;
        closes  = flags_i.valid && flags_i.last_comp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= '0;
            err_q      <= '1;
            best_q     <= '0;
            done_o     <= 1'b0;
            best_idx_o <= '0;
        end else begin
            done_o <= closes && flags_i.last_cv;
            if (flags_i.valid) acc_q <= acc_sum;
            if (closes) begin
                if (flags_i.last_cv) begin
                    err_q      <= '1;
                    best_q     <= '0;
                    best_idx_o <= better ? idx_i : best_q;
                end else if (better) begin
                    err_q  <= acc_sum;
                    best_q <= idx_i;
                end
            end
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/vq_search_engine.sv
`timescale 1ns/1ps
module vq_search_engine
    import vq_pkg::*;
#(
    parameter int DW   = 12,
    parameter int KMAX = 8,
    parameter int NMAX = 512,
    localparam int KW   = $clog2(KMAX + 1),
    localparam int NW   = $clog2(NMAX + 1),
    localparam int IDXW = $clog2(NMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_start,
    input  logic [DW-1:0]   vec_comp,
    input  logic [DW-1:0]   code_comp,
    input  logic [KW-1:0]   cfg_dim,
    input  logic [NW-1:0]   cfg_size,
    output logic            match_done,
    output logic [IDXW-1:0] match_idx
);

    localparam int SQW  = 2 * DW;
    localparam int ACCW = SQW + $clog2(KMAX);
    localparam int TW   = FLAG_W + IDXW;

    logic [DW-1:0]   x0, y0, mag2;
    vq_flags_t       f0, f4;
    logic [IDXW-1:0] idx0, idx4;
    logic [TW-1:0]   tag0, tag2, tag4;
    logic [SQW-1:0]  sq_term;
    logic [ACCW-1:0] err_ref;
    logic            t0_valid, sq_valid;

    vq_stream_tagger #(.DW(DW), .KMAX(KMAX), .NMAX(NMAX)) u_tag (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .vec_comp(vec_comp), .code_comp(code_comp),
        .cfg_dim(cfg_dim), .cfg_size(cfg_size),
        .x_q(x0), .y_q(y0), .flags_q(f0), .idx_q(idx0)
    );

    assign tag0     = {idx0, f0};
    assign t0_valid = f0.valid;

    vq_absdiff #(.DW(DW), .TW(TW)) u_abs (
        .clk(clk), .rst_n(rst_n), .a_i(x0), .b_i(y0), .tag_i(tag0),
        .mag_o(mag2), .tag_o(tag2)
    );

    vq_squarer #(.DW(DW), .TW(TW)) u_sq (
        .clk(clk), .rst_n(rst_n), .mag_i(mag2), .tag_i(tag2),
        .sq_o(sq_term), .tag_o(tag4)
    );

    assign f4       = vq_flags_t'(tag4[FLAG_W-1:0]);
    assign idx4     = tag4[TW-1:FLAG_W];
    assign sq_valid = f4.valid;

    vq_min_tracker #(.SQW(SQW), .KMAX(KMAX), .IDXW(IDXW)) u_min (
        .clk(clk), .rst_n(rst_n), .sq_i(sq_term), .flags_i(f4), .idx_i(idx4),
        .done_o(match_done), .best_idx_o(match_idx), .err_o(err_ref)
    );

endmodule

// File: rtl/vq_search_chk.sv
`timescale 1ns/1ps
module vq_search_chk #(
    parameter int DW   = 12,
    parameter int ACCW = 27,
    parameter int IDXW = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            t0_valid,
    input logic            sq_valid,
    input logic [2*DW-1:0] sq_term,
    input logic [ACCW-1:0] err_ref,
    input logic            match_done,
    input logic [IDXW-1:0] match_idx
);

    localparam logic [2*DW-1:0] SQ_LIMIT = (2*DW)'(((1 << DW) - 1) * ((1 << DW) - 1));

    always @(negedge clk) begin
        if (!rst_n) begin
            // R8
            reset_quiet_chk: assert (!match_done);
        end
    end

    // R6
    gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !t0_valid);

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_done |-> $stable(match_idx));

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_done |-> $past(in_valid, 6));

    // R10
    sq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> (sq_term <= SQ_LIMIT));

    // R3
    err_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_done |-> (err_ref == '1));

endmodule

bind vq_search_engine vq_search_chk #(.DW(DW), .ACCW(ACCW), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .t0_valid(t0_valid),
    .sq_valid(sq_valid), .sq_term(sq_term), .err_ref(err_ref),
    .match_done(match_done), .match_idx(match_idx)
);

// File: tb/tb_vq_search_engine.sv
`timescale 1ns/1ps
module tb_vq_search_engine;

    localparam int DW   = 12;
    localparam int KMAX = 8;
    localparam int NMAX = 512;
    localparam int KW   = $clog2(KMAX + 1);
    localparam int NW   = $clog2(NMAX + 1);
    localparam int IDXW = $clog2(NMAX);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_start = 1'b0;
    logic [DW-1:0]   vec_comp = '0;
    logic [DW-1:0]   code_comp = '0;
    logic [KW-1:0]   cfg_dim = '0;
    logic [NW-1:0]   cfg_size = '0;
    logic            match_done;
    logic [IDXW-1:0] match_idx;

    vq_search_engine #(.DW(DW), .KMAX(KMAX), .NMAX(NMAX)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .vec_comp(vec_comp), .code_comp(code_comp),
        .cfg_dim(cfg_dim), .cfg_size(cfg_size),
        .match_done(match_done), .match_idx(match_idx)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    int dones  = 0;
    int pushed = 0;
    bit ended  = 1'b0;
    int    exp_idx_q[$];
    int    exp_cyc_q[$];
    string exp_req_q[$];

    bit [31:0] lfsr = 32'h2545F491;
    int xv[8];
    int cb[64][8];

    function automatic int r12();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return int'(lfsr[11:0]) - 2048;
    endfunction

    task automatic check(bit ok, string req, string what, int got, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    // result monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n && match_done) begin
            int    ei;
            int    ec;
            string er;
            dones++;
            if (exp_idx_q.size() == 0) begin
                check(1'b0, "R7", "stray done strobe, index", int'(match_idx), -1);
            end else begin
                ei = exp_idx_q.pop_front();
                ec = exp_cyc_q.pop_front();
                er = exp_req_q.pop_front();
                check(int'(match_idx) == ei, er, "winning index", int'(match_idx), ei);
                check(cyc == ec, "R4", "done strobe cycle", cyc, ec);
            end
        end
    end

    task automatic drive(bit v, bit s, int x, int y, int kd, int nd);
        @(negedge clk);
        in_valid  = v;
        in_start  = s;
        vec_comp  = DW'(x);
        code_comp = DW'(y);
        cfg_dim   = KW'(kd);
        cfg_size  = NW'(nd);
    endtask

    task automatic idle(int n);
        for (int c = 0; c < n; c++) drive(1'b0, 1'b0, 0, 0, int'(cfg_dim), int'(cfg_size));
    endtask

    // mode 0 random, 1 forced tie, 2 all equal, 3 full range, 4 exact matches at 1 and 3
    task automatic run_search(int k, int n, bit st, int mode, bit gaps, bit noise, string req);
        int     best;
        longint bd;
        longint d;
        int     kd;
        int     nd;
        bit     first;
        for (int i = 0; i < k; i++) xv[i] = (mode == 3) ? -2048 : r12();
        for (int j = 0; j < n; j++) begin
            for (int i = 0; i < k; i++) begin
                case (mode)
                    2:       cb[j][i] = (j == 0) ? r12() : cb[0][i];
                    3:       cb[j][i] = (j == 0) ? 2047 : 2047 - ((j * 3 + i) % 7);
                    default: cb[j][i] = r12();
                endcase
            end
        end
        if (mode == 4) begin
            for (int i = 0; i < k; i++) begin
                if (n > 1) cb[1][i] = xv[i];
                if (n > 3) cb[3][i] = xv[i];
            end
        end
        best = 0;
        bd   = 0;
        for (int j = 0; j < n; j++) begin
            d = 0;
            for (int i = 0; i < k; i++) d += longint'(xv[i] - cb[j][i]) * longint'(xv[i] - cb[j][i]);
            if (j == 0 || d < bd) begin
                bd   = d;
                best = j;
            end
        end
        if (mode == 1 && n > 1) begin
            if (best == n - 1) begin
                for (int i = 0; i < k; i++) cb[0][i] = cb[n-1][i];
                best = 0;
            end else begin
                for (int i = 0; i < k; i++) cb[n-1][i] = cb[best][i];
            end
        end
        for (int j = 0; j < n; j++) begin
            for (int i = 0; i < k; i++) begin
                if (gaps && ((r12() & 3) == 0))
                    drive(1'b0, r12()[0], r12(), r12(), k, n);
                first = (j == 0 && i == 0);
                kd = (noise && !first) ? (k % KMAX) + 1 : k;
                nd = (noise && !first) ? (n % NMAX) + 2 : n;
                drive(1'b1, first && st, xv[i], cb[j][i], kd, nd);
            end
        end
        exp_idx_q.push_back(best);
        exp_cyc_q.push_back(cyc + 6);
        exp_req_q.push_back(req);
        pushed++;
    endtask

    task automatic partial(int k, int n, int count);
        for (int c = 0; c < count; c++)
            drive(1'b1, c == 0, r12(), r12(), k, n);
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        int ns[5] = '{1, 2, 3, 7, 16};
        int d0;
        bit first;
        repeat (3) @(negedge clk);
        // R8 / R4: outputs during reset
        check(match_done == 1'b0, "R8", "done during reset", int'(match_done), 0);
        check(match_idx == '0, "R4", "index during reset", int'(match_idx), 0);
        rst_n = 1'b1;
        idle(2);

        // R8: traffic without a start marker is ignored
        d0 = dones;
        for (int c = 0; c < 12; c++) drive(1'b1, 1'b0, r12(), r12(), 4, 2);
        idle(10);
        check(dones == d0, "R8", "strobes from pre-start traffic", dones - d0, 0);
        check(match_idx == '0, "R8", "index after pre-start traffic", int'(match_idx), 0);

        // R1: every dimension against several sizes, one unbroken stream
        first = 1'b1;
        for (int k = 1; k <= KMAX; k++) begin
            foreach (ns[q]) begin
                run_search(k, ns[q], first, 0, 1'b0, 1'b0, "R1");
                first = 1'b0;
            end
        end
        // R5: back-to-back including single-cycle searches
        run_search(3, 4, 1'b0, 0, 1'b0, 1'b0, "R5");
        run_search(6, 5, 1'b0, 0, 1'b0, 1'b0, "R5");
        run_search(1, 1, 1'b0, 0, 1'b0, 1'b0, "R5");
        run_search(1, 1, 1'b0, 0, 1'b0, 1'b0, "R5");
        run_search(1, 3, 1'b0, 0, 1'b0, 1'b0, "R5");
        idle(8);

        // R2: ties keep the lower index
        run_search(4, 8, 1'b1, 1, 1'b0, 1'b0, "R2");
        run_search(4, 5, 1'b0, 2, 1'b0, 1'b0, "R2");
        run_search(3, 6, 1'b0, 4, 1'b0, 1'b0, "R2");
        run_search(1, 9, 1'b0, 1, 1'b0, 1'b0, "R2");

        // R3: a zero-distortion search followed by an ordinary one
        run_search(5, 6, 1'b0, 4, 1'b0, 1'b0, "R3");
        run_search(5, 6, 1'b0, 0, 1'b0, 1'b0, "R3");
        run_search(2, 4, 1'b0, 4, 1'b0, 1'b0, "R3");
        run_search(2, 7, 1'b0, 0, 1'b0, 1'b0, "R3");

        // R10: full-range differences
        run_search(8, 16, 1'b0, 3, 1'b0, 1'b0, "R10");
        run_search(8, 2, 1'b0, 3, 1'b0, 1'b0, "R10");

        // R6: idle cycles with junk data and markers
        run_search(4, 10, 1'b0, 0, 1'b1, 1'b0, "R6");
        run_search(7, 6, 1'b0, 0, 1'b1, 1'b0, "R6");
        run_search(1, 12, 1'b0, 0, 1'b1, 1'b0, "R6");

        // R9: configuration changes during a search
        run_search(4, 6, 1'b0, 0, 1'b0, 1'b1, "R9");
        run_search(2, 9, 1'b0, 0, 1'b1, 1'b1, "R9");
        run_search(8, 3, 1'b0, 0, 1'b0, 1'b1, "R9");

        // R7: partial searches cut by a fresh marker
        partial(4, 8, 13);
        run_search(5, 4, 1'b1, 0, 1'b0, 1'b0, "R7");
        partial(2, 3, 5);
        run_search(3, 3, 1'b1, 0, 1'b0, 1'b0, "R7");

        // R1: larger codebooks
        run_search(2, 64, 1'b0, 0, 1'b0, 1'b0, "R1");
        run_search(8, 40, 1'b0, 0, 1'b0, 1'b0, "R1");

        idle(20);
        check(exp_idx_q.size() == 0, "R5", "searches without a strobe", exp_idx_q.size(), 0);
        check(dones == pushed, "R5", "strobe count", dones, pushed);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog expired: got %0d strobes expected %0d", dones, pushed);
            finish_up();
        end
    end

endmodule